// File: doc/BRIEF.md
# Frame Buffer Loader

This block takes a stream of 8-bit colour intensities from a byte FIFO and stores them into an on-chip frame store that holds one 32x32 RGB image. The store is kept as three separate colour planes of 8-bit values. The first third of each frame fills the red plane, the second third fills the green plane and the last third fills the blue plane. Within each plane the pixels are written row by row.

The loader pops one byte from the FIFO only when the FIFO reports data. It writes that byte at the current plane, row and column, then moves on to the next position. After the last blue pixel it raises a one-clock completion pulse and returns to the first red pixel. The next frame then overwrites the stored image, so a sender can stream an animation frame after frame. A separate read port lets a display scanner fetch any stored intensity at any time, even while a new frame is being loaded.

Top module: `frame_loader`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the clock after it, `fifo_rd` and `frame_done` are low. After reset the next byte goes to plane 0, row 0, column 0. The stored intensities are not cleared.
- R2: `fifo_rd` is raised only in a clock where `fifo_present` is high. Each strobe lasts exactly one clock and removes exactly one byte. The byte stored is the value on `fifo_data` during that strobe clock.
- R3: Within a frame, bytes 0 to 1023 go to plane 0 (red), bytes 1024 to 2047 go to plane 1 (green) and bytes 2048 to 3071 go to plane 2 (blue). `scan_plane` uses the same codes 0, 1 and 2.
- R4: Byte k of a plane is stored at row k/32, column k%32 (row-major order).
- R5: `frame_done` is a single-clock pulse. It is high exactly 3 clocks after the strobe that takes the 3072nd byte of a frame. The byte after that goes to plane 0, row 0, column 0.
- R6: Bytes of the next frame are taken at once, with no wait after `frame_done`, and they overwrite the stored image.
- R7: `scan_data` shows the intensity stored at (`scan_plane`, `scan_row`, `scan_col`) as those inputs were in the previous clock. Reads work while loading goes on and have no effect on loading.
- R8: Two strobes are never closer than 4 clocks apart. While `fifo_present` stays high, strobes are exactly 4 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data | input | 8 | Byte at the head of the receive FIFO |
| fifo_present | input | 1 | The FIFO holds at least one byte |
| fifo_rd | output | 1 | Pop strobe for the FIFO, one clock per byte |
| frame_done | output | 1 | One-clock pulse when a whole frame has been stored |
| scan_plane | input | 2 | Plane to read: 0 red, 1 green, 2 blue |
| scan_row | input | 5 | Row to read |
| scan_col | input | 5 | Column to read |
| scan_data | output | 8 | Stored intensity, one clock after the address |

## Verification
The bench starves the FIFO partway through a frame. A loader that ignored the data-present flag would strobe an empty FIFO, and one that lost track of its position would store the later bytes at the wrong places. The bench also reads back a full frame while the next frame streams in. Plane-dependent byte values show any swap of planes or of rows and columns as a mismatch. A wrap counted off by one would also fail, because it shifts every pixel of the following frame and moves the completion pulse. The bench resets the block in the middle of a frame and then loads a complete frame. A design that kept its old write position would leave that frame rotated in the store.

// File: rtl/frame_pkg.sv
package frame_pkg;

    typedef enum logic [1:0] {
        LD_IDLE    = 2'd0,
        LD_READ    = 2'd1,
        LD_WRITE   = 2'd2,
        LD_ADVANCE = 2'd3
    } ld_state_e;

endpackage

// File: rtl/fb_loader_fsm.sv
module fb_loader_fsm
    import frame_pkg::*;
#(
    parameter int DW     = 8,
    parameter int ROWS   = 32,
    parameter int COLS   = 32,
    parameter int PLANES = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DW-1:0]             fifo_data,
    input  logic                      fifo_present,
    output logic                      fifo_rd,
    output logic                      wr_en,
    output logic [$clog2(PLANES)-1:0] wr_plane,
    output logic [$clog2(ROWS)-1:0]   wr_row,
    output logic [$clog2(COLS)-1:0]   wr_col,
    output logic [DW-1:0]             wr_data,
    output logic                      frame_done
);
    localparam int PW = $clog2(PLANES);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam logic [PW-1:0] LAST_PLANE = PW'(PLANES - 1);
    localparam logic [RW-1:0] LAST_ROW   = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL   = CW'(COLS - 1);

    typedef struct packed {
        ld_state_e     state;
        logic [PW-1:0] plane;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic [DW-1:0] data;
        logic          done;
    } ld_regs_t;

    ld_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        fifo_rd = 1'b0;
        wr_en   = 1'b0;
        case (r_q.state)
            LD_IDLE: begin
                if (fifo_present) begin
                    r_d.state = LD_READ;
                end
            end
            LD_READ: begin
                fifo_rd   = 1'b1;
                r_d.data  = fifo_data;
                r_d.state = LD_WRITE;
            end
            LD_WRITE: begin
                wr_en     = 1'b1;
                r_d.state = LD_ADVANCE;
            end
            LD_ADVANCE: begin
                r_d.state = LD_IDLE;
                if (r_q.col == LAST_COL) begin
                    r_d.col = '0;
                    if (r_q.row == LAST_ROW) begin
                        r_d.row = '0;
                        if (r_q.plane == LAST_PLANE) begin
                            r_d.plane = '0;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.plane = r_q.plane + 1'b1;
                        end
                    end else begin
                        r_d.row = r_q.row + 1'b1;
                    end
                end else begin
                    r_d.col = r_q.col + 1'b1;
                end
            end
            default: r_d.state = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_plane   = r_q.plane;
    assign wr_row     = r_q.row;
    assign wr_col     = r_q.col;
    assign wr_data    = r_q.data;
    assign frame_done = r_q.done;

endmodule

// File: rtl/fb_plane_ram.sv
module fb_plane_ram #(
    parameter int DW = 8,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/frame_loader.sv
module frame_loader #(
    parameter int DW     = 8,
    parameter int ROWS   = 32,
    parameter int COLS   = 32,
    parameter int PLANES = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DW-1:0]             fifo_data,
    input  logic                      fifo_present,
    output logic                      fifo_rd,
    output logic                      frame_done,
    input  logic [$clog2(PLANES)-1:0] scan_plane,
    input  logic [$clog2(ROWS)-1:0]   scan_row,
    input  logic [$clog2(COLS)-1:0]   scan_col,
    output logic [DW-1:0]             scan_data
);
    localparam int PW = $clog2(PLANES);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam int AW = RW + CW;

    logic          wr_en;
    logic [PW-1:0] wr_plane;
    logic [RW-1:0] wr_row;
    logic [CW-1:0] wr_col;
    logic [DW-1:0] wr_data;
    logic [PW-1:0] sel_q, sel_d;
    logic [DW-1:0] plane_rdata [PLANES];

    fb_loader_fsm #(
        .DW(DW), .ROWS(ROWS), .COLS(COLS), .PLANES(PLANES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fifo_data    (fifo_data),
        .fifo_present (fifo_present),
        .fifo_rd      (fifo_rd),
        .wr_en        (wr_en),
        .wr_plane     (wr_plane),
        .wr_row       (wr_row),
        .wr_col       (wr_col),
        .wr_data      (wr_data),
        .frame_done   (frame_done)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        fb_plane_ram #(.DW(DW), .AW(AW)) u_ram (
            .clk   (clk),
            .we    (wr_en && (wr_plane == PW'(p))),
            .waddr ({wr_row, wr_col}),
            .wdata (wr_data),
            .raddr ({scan_row, scan_col}),
            .rdata (plane_rdata[p])
        );
    end

    always_comb begin
        sel_d = scan_plane;
    end

    always_ff @(posedge clk) begin
        sel_q <= sel_d;
    end

    always_comb begin
        scan_data = '0;
        for (int p = 0; p < PLANES; p++) begin
            if (sel_q == PW'(p)) begin
                scan_data = plane_rdata[p];
            end
        end
    end

endmodule

// File: rtl/frame_loader_chk.sv
module frame_loader_chk #(
    parameter int ROWS   = 32,
    parameter int COLS   = 32,
    parameter int PLANES = 3
) (
    input logic clk,
    input logic rst,
    input logic fifo_present,
    input logic fifo_rd,
    input logic frame_done
);
    localparam int FRAME = ROWS * COLS * PLANES;
    localparam int NW    = $clog2(FRAME + 1);

    logic [NW-1:0] rd_cnt_q;
    logic [2:0]    gap_q;
    logic          any_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt_q <= '0;
            gap_q    <= 3'd7;
            any_rd_q <= 1'b0;
        end else if (fifo_rd) begin
            rd_cnt_q <= (rd_cnt_q == NW'(FRAME - 1)) ? '0 : rd_cnt_q + 1'b1;
            gap_q    <= 3'd0;
            any_rd_q <= 1'b1;
        end else if (gap_q != 3'd7) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!fifo_rd && !frame_done));

    p_rd_needs_data_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> fifo_present);

    p_rd_single_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !fifo_rd);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_done_on_frame_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (any_rd_q && rd_cnt_q == '0));

    p_cadence_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> (gap_q >= 3'd3));

endmodule

bind frame_loader frame_loader_chk #(
    .ROWS(ROWS), .COLS(COLS), .PLANES(PLANES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fifo_present (fifo_present),
    .fifo_rd      (fifo_rd),
    .frame_done   (frame_done)
);

// File: tb/sim_frame_loader.sv
module sim_frame_loader;
    localparam int FRAME = 3072;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_present = 1'b0;
    logic       fifo_rd;
    logic       frame_done;
    logic [1:0] scan_plane = 2'd0;
    logic [4:0] scan_row = 5'd0;
    logic [4:0] scan_col = 5'd0;
    logic [7:0] scan_data;

    frame_loader u0 (
        .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_present(fifo_present),
        .fifo_rd(fifo_rd), .frame_done(frame_done), .scan_plane(scan_plane),
        .scan_row(scan_row), .scan_col(scan_col), .scan_data(scan_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int done_cnt = 0;
    logic [7:0] fq[$];
    logic [7:0] sb[$];
    logic pop_req = 1'b0;
    int consumed = 0;
    int gap = 99;
    bit seen_empty = 1'b1;
    int last_rd = 0;
    bit prev_done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((k * 37) + (seed * 101) + ((k >> 10) * 59) + (k >> 5));
    endfunction

    // Driver: feeds the FIFO model and the expected queue
    task automatic push_bytes(input int seed, input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            fq.push_back(pat(seed, k));
            sb.push_back(pat(seed, k));
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        pop_req <= fifo_rd;
    end

    // Monitor and FIFO model, all at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            consumed = 0;
            gap = 99;
            seen_empty = 1'b1;
            prev_done = 1'b0;
        end else begin
            if (!fifo_present) seen_empty = 1'b1;
            if (fifo_rd) begin
                chk(fifo_present, "R2", 0, 1, "strobe while FIFO empty");
                chk(gap >= 3, "R8", gap, 3, "idle clocks between strobes");
                if (!seen_empty) chk(gap == 3, "R8", gap, 3, "back-to-back cadence");
                gap = 0;
                seen_empty = !fifo_present;
                consumed++;
                last_rd = cyc;
            end else begin
                gap++;
            end
            if (frame_done) begin
                chk(!prev_done, "R5", 1, 0, "done longer than one clock");
                chk(cyc - last_rd == 3, "R5", cyc - last_rd, 3, "done delay after last strobe");
                chk(consumed % FRAME == 0, "R5", consumed % FRAME, 0, "bytes at done");
                done_cnt++;
            end
            prev_done = frame_done;
        end
        if (pop_req && fq.size() > 0) void'(fq.pop_front());
        fifo_present = (fq.size() > 0);
        fifo_data = (fq.size() > 0) ? fq[0] : 8'h00;
    end

    // Scoreboard readback: plane, row, col order pops the expected queue
    task automatic readback(input string req);
        for (int pl = 0; pl < 3; pl++)
            for (int rw = 0; rw < 32; rw++)
                for (int cl = 0; cl < 32; cl++) begin
                    logic [7:0] e;
                    @(negedge clk);
                    scan_plane = 2'(pl);
                    scan_row = 5'(rw);
                    scan_col = 5'(cl);
                    @(negedge clk);
                    e = sb.pop_front();
                    chk(scan_data == e, req, scan_data, e, "stored byte (R3 R4 R7)");
                end
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(fifo_rd == 1'b0, "R1", fifo_rd, 0, "strobe in reset");
        chk(frame_done == 1'b0, "R1", frame_done, 0, "done in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(fifo_rd == 1'b0 && frame_done == 1'b0, "R1", fifo_rd, 0, "outputs after reset");
        repeat (20) @(negedge clk);   // empty FIFO: monitor flags any strobe (R2)

        // Frame A with a starved gap in the middle of the red plane
        push_bytes(1, 0, 700);
        while (fq.size() > 0) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(done_cnt == 0, "R5", done_cnt, 0, "done before frame end");
        push_bytes(1, 700, FRAME);
        wait_done(1);

        // Frame B streams in at once while frame A is read back (R6, R7)
        push_bytes(2, 0, FRAME);
        readback("R7");
        wait_done(2);
        chk(done_cnt == 2, "R6", done_cnt, 2, "frame count");
        readback("R6");

        // Reset in the middle of a frame, then a fresh frame (R1)
        for (int k = 0; k < 500; k++) fq.push_back(8'(k * 13 + 5));
        repeat (400) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        fq.delete();
        chk(fifo_rd == 1'b0, "R1", fifo_rd, 0, "strobe in mid-frame reset");
        rst = 1'b0;
        push_bytes(3, 0, FRAME);
        wait_done(3);
        readback("R1");
        chk(done_cnt == 3, "R5", done_cnt, 3, "total frame pulses");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule